// File: doc/BRIEF.md
# Double-Word Address/Data Validator

This block sits behind a receiver front end that has already turned the line pulses into three-state symbols. It puts the symbols of each word together. The first five symbols form an address, which the block compares with a local three-state address. The next four symbols form a nibble of data. The data reaches the outputs only after the block has seen the same address and the same nibble in two words in a row. At that point it raises a valid-transmission flag.

The front end marks the end of each word and the end of a transmission with single-cycle strobes. The block only accepts data that was repeated inside one sequence, so a single corrupted word never reaches the data outputs. The last accepted nibble stays on the outputs until another repeated nibble replaces it.

Top module: `dw_frame_validator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `tx_valid` is 0 and `data_out` is 0.
- R2: Symbol codes are 00 low, 01 high, 10 open and 11 reserved. The k-th received symbol of a word (k = 0..4) is compared for exact code equality with `local_addr[2k+1:2k]`. Symbols 5..8 carry data bits 0..3.
- R3: The first matching word after the flag was cleared (or after reset) stores its nibble internally. It leaves `data_out` unchanged and `tx_valid` low.
- R4: A matching word whose nibble equals the stored one, arriving directly after another matching word, copies the nibble to `data_out` and sets `tx_valid`. Both outputs change on the clock edge that samples `word_end`.
- R5: In a data position, low decodes to 0. High, open and reserved all decode to 1.
- R6: A word whose address does not match clears `tx_valid` and the run of consecutive matches. A single matching word that follows it does not set the flag.
- R7: A matching word whose nibble differs from the stored one clears `tx_valid` and the match run, and leaves `data_out` unchanged.
- R8: A word that does not hold exactly nine symbols when `word_end` arrives counts as a mismatch.
- R9: `tx_end` clears `tx_valid` and the match run, and throws away any symbols gathered so far.
- R10: `data_out` holds its value until a newly validated nibble replaces it.
- R11: While the flag is set, further matching words with the same nibble keep `tx_valid` high.
- R12: When `word_end` and `tx_end` arrive in the same cycle, `tx_end` wins: the word is thrown away and the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A symbol is present on `sym_value` this cycle |
| sym_value | input | 2 | Symbol code (00 low, 01 high, 10 open, 11 reserved) |
| word_end | input | 1 | Strobe: the current word is complete |
| tx_end | input | 1 | Strobe: the input has been silent long enough to end the transmission |
| local_addr | input | 10 | Local address, five two-bit symbol codes, digit 0 in the low bits |
| data_out | output | 4 | Last validated data nibble |
| tx_valid | output | 1 | Valid-transmission flag |

## Verification
The hardest case to reach from the ports is a single matching word that follows a cleared run. From the outside it looks just like the second word of a good pair, so the only sign of a correct design is that the flag stays low. The stimulus reaches this case by breaking a run in each of the possible ways: a wrong address, a different nibble, a short word, a long word, an end-of-transmission, and an end-of-word that arrives together with an end-of-transmission. After each break it sends exactly one good word and checks that the flag is still low, then sends a second good word and checks that the flag rises. A scoreboard model, written from the requirements alone, predicts the flag and the nibble after every strobe.

// File: rtl/dwv_pkg.sv
package dwv_pkg;
  typedef logic [1:0] sym_t;

  localparam sym_t SYM_LOW  = 2'b00;
  localparam sym_t SYM_HIGH = 2'b01;
  localparam sym_t SYM_OPEN = 2'b10;

  // Data decoding: only a hard low is 0; high, open and reserved give 1.
  function automatic logic sym_to_bit(input sym_t s);
    return (s != SYM_LOW);
  endfunction

  // Exact code equality between one received and one local digit.
  function automatic logic digit_equal(input sym_t rx, input sym_t loc);
    return (rx == loc);
  endfunction
endpackage

// File: rtl/dwv_word_assembler.sv
module dwv_word_assembler #(
  parameter int WORD_SYMS = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sym_valid,
  input  logic [1:0]             sym_value,
  input  logic                   word_end,
  input  logic                   tx_end,
  output logic [2*WORD_SYMS-1:0] word_syms,
  output logic                   len_ok
);
  localparam int CNT_MAX = WORD_SYMS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] sym_cnt;
  logic             restart;

  // A strobe closes the word; a symbol in the same cycle opens the next one.
  assign restart = word_end | tx_end;
  assign len_ok  = (sym_cnt == CNT_W'(WORD_SYMS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_cnt <= '0;
    end else if (restart) begin
      sym_cnt <= sym_valid ? CNT_W'(1) : '0;
    end else if (sym_valid && sym_cnt != CNT_W'(CNT_MAX)) begin
      sym_cnt <= sym_cnt + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < WORD_SYMS; g++) begin : g_slot
    logic slot_we;
    assign slot_we = sym_valid &&
                     (restart ? (g == 0) : (sym_cnt == CNT_W'(g)));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_syms[2*g +: 2] <= 2'b00;
      end else if (slot_we) begin
        word_syms[2*g +: 2] <= sym_value;
      end
    end
  end
endmodule

// File: rtl/dwv_addr_compare.sv
module dwv_addr_compare
  import dwv_pkg::*;
#(
  parameter int ADDR_SYMS = 5
) (
  input  logic [2*ADDR_SYMS-1:0] rx_addr,
  input  logic [2*ADDR_SYMS-1:0] local_addr,
  output logic                   addr_hit
);
  logic [ADDR_SYMS-1:0] digit_ok;

  for (genvar g = 0; g < ADDR_SYMS; g++) begin : g_digit
    assign digit_ok[g] = digit_equal(rx_addr[2*g +: 2], local_addr[2*g +: 2]);
  end

  assign addr_hit = &digit_ok;
endmodule

// File: rtl/dwv_word_judge.sv
module dwv_word_judge
  import dwv_pkg::*;
#(
  parameter int DATA_SYMS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   word_end,
  input  logic                   tx_end,
  input  logic                   word_good,
  input  logic [2*DATA_SYMS-1:0] rx_data_syms,
  output logic [DATA_SYMS-1:0]   data_out,
  output logic                   tx_valid
);
  typedef enum logic [1:0] {RUN_NONE, RUN_ONE, RUN_TWO} run_t;

  run_t                 run;
  logic [DATA_SYMS-1:0] held_nib;
  logic [DATA_SYMS-1:0] rx_nib;
  logic                 nib_same;

  for (genvar g = 0; g < DATA_SYMS; g++) begin : g_bit
    assign rx_nib[g] = sym_to_bit(rx_data_syms[2*g +: 2]);
  end

  assign nib_same = (rx_nib == held_nib);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= RUN_NONE;
      held_nib <= '0;
      data_out <= '0;
      tx_valid <= 1'b0;
    end else if (tx_end) begin
      run      <= RUN_NONE;
      tx_valid <= 1'b0;
    end else if (word_end) begin
      if (!word_good) begin
        run      <= RUN_NONE;
        tx_valid <= 1'b0;
      end else if (run == RUN_NONE) begin
        run      <= RUN_ONE;
        held_nib <= rx_nib;
      end else if (nib_same) begin
        run      <= RUN_TWO;
        data_out <= rx_nib;
        tx_valid <= 1'b1;
      end else begin
        run      <= RUN_NONE;
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dw_frame_validator.sv
module dw_frame_validator #(
  parameter int ADDR_SYMS = 5,
  parameter int DATA_SYMS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sym_valid,
  input  logic [1:0]             sym_value,
  input  logic                   word_end,
  input  logic                   tx_end,
  input  logic [2*ADDR_SYMS-1:0] local_addr,
  output logic [DATA_SYMS-1:0]   data_out,
  output logic                   tx_valid
);
  localparam int WORD_SYMS = ADDR_SYMS + DATA_SYMS;

  logic [2*WORD_SYMS-1:0] word_syms;
  logic                   len_ok;
  logic                   addr_hit;
  logic                   word_good;
  logic                   word_evt;

  assign word_evt  = word_end & ~tx_end;
  assign word_good = len_ok & addr_hit;

  dwv_word_assembler #(.WORD_SYMS(WORD_SYMS)) i_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_value (sym_value),
    .word_end  (word_end),
    .tx_end    (tx_end),
    .word_syms (word_syms),
    .len_ok    (len_ok)
  );

  dwv_addr_compare #(.ADDR_SYMS(ADDR_SYMS)) i_cmp (
    .rx_addr    (word_syms[2*ADDR_SYMS-1:0]),
    .local_addr (local_addr),
    .addr_hit   (addr_hit)
  );

  dwv_word_judge #(.DATA_SYMS(DATA_SYMS)) i_judge (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_end     (word_end),
    .tx_end       (tx_end),
    .word_good    (word_good),
    .rx_data_syms (word_syms[2*WORD_SYMS-1:2*ADDR_SYMS]),
    .data_out     (data_out),
    .tx_valid     (tx_valid)
  );
endmodule

// File: rtl/dwv_checker.sv
module dwv_checker #(
  parameter int DATA_SYMS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 word_evt,
  input logic                 word_good,
  input logic                 tx_end,
  input logic                 tx_valid,
  input logic [DATA_SYMS-1:0] data_out
);
  // R4: the flag can only rise right after a good word.
  a_r4_rise_after_good_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(word_evt && word_good));

  // R6 / R8: a bad word clears the flag.
  a_r6_bad_word_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (word_evt && !word_good) |=> !tx_valid);

  // R9 / R12: end of transmission clears the flag.
  a_r9_tx_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> !tx_valid);

  // R10: the outputs hold between words.
  a_r10_hold_without_word: assert property (@(posedge clk) disable iff (!rst_n)
    !word_evt |=> $stable(data_out));

  // R7 / R10: new data appears only together with a set flag.
  a_r7_data_change_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> tx_valid);
endmodule

bind dw_frame_validator dwv_checker #(.DATA_SYMS(DATA_SYMS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_evt  (word_evt),
  .word_good (word_good),
  .tx_end    (tx_end),
  .tx_valid  (tx_valid),
  .data_out  (data_out)
);

// File: tb/test_dw_frame_validator.sv
`timescale 1ns/1ps
module test_dw_frame_validator;
  localparam logic [9:0] LOCAL = 10'b01_10_00_10_01;
  localparam logic [9:0] OTHER = 10'b01_10_10_10_01;

  typedef struct {
    logic       v;
    logic [3:0] d;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym_value = 2'b00;
  logic       word_end = 1'b0;
  logic       tx_end = 1'b0;
  logic [3:0] data_out;
  logic       tx_valid;

  int   errors = 0;
  int   checks = 0;
  exp_t q[$];
  bit   done = 0;

  // scoreboard model state
  int         m_run = 0;
  logic [3:0] m_held = 4'h0;
  logic [3:0] m_out = 4'h0;
  logic       m_valid = 1'b0;

  always #4 clk = ~clk;

  dw_frame_validator i_dw_frame_validator (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_value(sym_value),
    .word_end(word_end), .tx_end(tx_end), .local_addr(LOCAL),
    .data_out(data_out), .tx_valid(tx_valid)
  );

  task automatic push(input string tag);
    exp_t e;
    e.v = m_valid; e.d = m_out; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    sym_valid = 0; word_end = 0; tx_end = 0;
  endtask

  // n symbols, then the end-of-word strobe (with_eot adds tx_end, R12)
  task automatic send(input logic [9:0] a, input logic [7:0] dsy,
                      input int n, input bit with_eot, input string tag);
    logic [3:0] nib;
    bit ok;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      word_end = 0; tx_end = 0; sym_valid = 1;
      if (i < 5) sym_value = a[2*i +: 2];
      else if (i < 9) sym_value = dsy[2*(i-5) +: 2];
      else sym_value = 2'b01;
    end
    @(posedge clk); #1;
    sym_valid = 0; word_end = 1; tx_end = with_eot;
    for (int b = 0; b < 4; b++) nib[b] = (dsy[2*b +: 2] != 2'b00);
    ok = (n == 9) && (a == LOCAL);
    if (with_eot) begin
      m_run = 0; m_valid = 0;
    end else if (!ok) begin
      m_run = 0; m_valid = 0;
    end else if (m_run == 0) begin
      m_run = 1; m_held = nib;
    end else if (nib == m_held) begin
      m_run = 2; m_out = nib; m_valid = 1;
    end else begin
      m_run = 0; m_valid = 0;
    end
    push(tag);
    idle();
  endtask

  task automatic partial_then_eot(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sym_valid = 1; sym_value = LOCAL[2*(i%5) +: 2];
    end
    @(posedge clk); #1;
    sym_valid = 0; tx_end = 1;
    m_run = 0; m_valid = 0;
    push(tag);
    idle();
  endtask

  // monitor: a strobe seen at one negedge is judged at the next
  initial begin
    bit pending = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (pending) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: result with no expected item");
        end else begin
          e = q.pop_front();
          if (tx_valid !== e.v || data_out !== e.d) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     e.tag, tx_valid, data_out, e.v, e.d);
          end
        end
      end
      pending = rst_n && (word_end || tx_end);
    end
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: run did not end (got timeout, expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    checks++;
    if (tx_valid !== 1'b0 || data_out !== 4'h0) begin
      errors++;
      $display("FAIL R1 in reset: got valid=%0b data=%h, expected 0 0", tx_valid, data_out);
    end
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (tx_valid !== 1'b0 || data_out !== 4'h0) begin
      errors++;
      $display("FAIL R1 after reset: got valid=%0b data=%h, expected 0 0", tx_valid, data_out);
    end

    // R2 R3 R4: data 1010 sent twice
    send(LOCAL, 8'b01_00_01_00, 9, 0, "R3 first word stored only");
    send(LOCAL, 8'b01_00_01_00, 9, 0, "R4 second word validates");
    send(LOCAL, 8'b01_00_01_00, 9, 0, "R11 continuous repeat keeps flag");
    send(LOCAL, 8'b01_00_01_00, 9, 0, "R11 continuous repeat again");
    partial_then_eot(0, "R9 tx_end clears flag, R10 data held");
    // R5: open and reserved decode to 1 (expect 1101)
    send(LOCAL, 8'b11_10_00_10, 9, 0, "R5 first word with open data");
    send(LOCAL, 8'b11_10_00_10, 9, 0, "R5 open and reserved data as 1");
    // R6: address mismatch, then single good word must not validate
    send(OTHER, 8'b11_10_00_10, 9, 0, "R6 address mismatch clears");
    send(LOCAL, 8'b00_01_01_00, 9, 0, "R6 one match after clear");
    send(LOCAL, 8'b00_01_01_00, 9, 0, "R6 second match validates");
    // R7: data mismatch on second word
    partial_then_eot(0, "R9 end sequence");
    send(LOCAL, 8'b00_00_00_01, 9, 0, "R7 first word");
    send(LOCAL, 8'b00_00_01_00, 9, 0, "R7 data mismatch keeps old data");
    send(LOCAL, 8'b00_00_01_00, 9, 0, "R7 run restarted, no flag");
    send(LOCAL, 8'b00_00_01_00, 9, 0, "R7 then validates");
    // R8: short and long words
    send(LOCAL, 8'b01_01_01_01, 8, 0, "R8 short word is mismatch");
    send(LOCAL, 8'b01_01_01_01, 9, 0, "R8 one match after short");
    send(LOCAL, 8'b01_01_01_01, 10, 0, "R8 long word is mismatch");
    send(LOCAL, 8'b01_01_01_01, 9, 0, "R8 one match after long");
    send(LOCAL, 8'b01_01_01_01, 9, 0, "R8 pair validates");
    // R9: partial word discarded by tx_end
    partial_then_eot(4, "R9 partial word then tx_end");
    send(LOCAL, 8'b00_01_00_01, 9, 0, "R9 first word after discard");
    send(LOCAL, 8'b00_01_00_01, 9, 0, "R9 pair validates");
    // R12: word_end together with tx_end
    partial_then_eot(0, "R12 end sequence");
    send(LOCAL, 8'b01_00_00_00, 9, 0, "R12 first word");
    send(LOCAL, 8'b01_00_00_00, 9, 1, "R12 tx_end wins over word_end");
    send(LOCAL, 8'b01_00_00_00, 9, 0, "R12 run was cleared");
    send(LOCAL, 8'b01_00_00_00, 9, 0, "R12 pair validates");

    repeat (4) idle();
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d unchecked items, expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule